// File: doc/BRIEF.md
# SDRAM Auto-Precharge Interrupt Sequencer

This block models the device side of a four-bank SDRAM for one case: a write burst that was issued with auto precharge and is cut short by a READ or a WRITE to another bank. Commands arrive already registered, one per clock. Each READ or WRITE command carries an auto-precharge flag, a bank and a column. A write burst places one data beat into a small internal array on every clock. A read burst fetches one beat per clock and presents it on the read data output after the CAS latency.

Every bank has its own state machine and down-counter. An accepted command to a new bank ends the burst in progress on the clock it is registered. If the truncated burst was a write with auto precharge, its bank starts its write-recovery interval on that same clock. After that interval it moves to precharge by itself and then becomes idle. The new bank's burst runs at the same time. Row activation is out of scope, so every bank leaves reset with a row open. A bank that has gone idle accepts no further reads or writes.

Top module: `sdram_ap_seq`

## Requirements
- R1: After reset every bank reports the open-row state. The state codes on `bank_state_o` (3 bits per bank, bank b at bits 3b+2..3b) are 0 idle, 1 open, 2 writing, 3 reading, 4 write recovery and 5 precharging. After reset the write strobe and the read output enable are low. Command code 3 on `cmd_i` behaves as a no-operation (0 no-op, 1 READ, 2 WRITE).
- R2: A WRITE writes its first beat in the same cycle the command is presented, at the given column, and raises `mem_we_o` with `wdata_i`. The following three cycles write the next beats. The low two column bits count up and wrap modulo 4, and the upper column bits stay fixed. The bank reports writing until the burst ends.
- R3: An accepted READ or WRITE ends any burst in progress on the clock it is registered. Only the beats strobed in earlier cycles reach the old bank. Banks that are not involved keep their state, and at most one bank is ever in the writing or reading state.
- R4: A write burst with auto precharge that is truncated reports write recovery from the cycle after the interrupting command, for WR_REC_CYC cycles (default 2). It then reports precharging for PRECH_CYC cycles (default 3), and idle after that.
- R5: A write burst with auto precharge that delivers all four beats enters write recovery in the cycle after its fourth beat and then follows the sequence of R4. A burst without auto precharge returns its bank to the open state when it ends.
- R6: A READ fetches four beats using the column order of R2. Beat j is on `rdata_o` with `rdata_oe_o` high in the cycle CAS_LAT+j cycles after the command cycle (CAS_LAT defaults to 3). At all other times the enable is low. The bank reports reading until its fourth fetch.
- R7: A READ with auto precharge reports precharging in the cycle after its fourth fetch, for PRECH_CYC cycles, and then idle.
- R8: A READ or WRITE is rejected if its bank is in write recovery, precharging or idle, or if its bank owns an auto-precharge burst still in progress. The rejection is shown by `cmd_err_o` high in the same cycle. A rejected command writes nothing, starts no read data, changes no bank state and leaves any burst in progress running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 2 | Command code: 0 no-op, 1 READ, 2 WRITE, 3 no-op |
| ap_i | input | 1 | Auto-precharge flag of the command |
| bank_i | input | 2 | Target bank |
| col_i | input | 4 | Starting column |
| wdata_i | input | 16 | Write data for the current beat |
| bank_state_o | output | 12 | Per-bank state codes, 3 bits each |
| mem_we_o | output | 1 | Write strobe into the array |
| mem_bank_o | output | 2 | Bank of the current beat |
| mem_col_o | output | 4 | Column of the current beat |
| mem_wdata_o | output | 16 | Data written this cycle |
| rdata_o | output | 16 | Read data, zero when not enabled |
| rdata_oe_o | output | 1 | Read output enable |
| cmd_err_o | output | 1 | Command rejected this cycle |

## Verification
The bench covers every ordered pair of distinct banks, every interrupt point inside the first burst, and both READ and WRITE as the interrupting command, with and without auto precharge. One design fault it targets is a late cut-off, which would leak an extra beat of the old burst into the array. Another is a recovery timer started from the old burst's natural end, which would stretch write recovery, or that skips recovery, which would shorten it. It also targets column wrap taken across the aligned group of four, which would read or write the wrong column. Rejected commands are injected while the truncated bank is recovering, precharging and idle, and while another burst is in flight. A design that let any of them through would stop that burst, produce extra read beats or reopen a closed bank.

// File: rtl/sdram_ap_pkg.sv
package sdram_ap_pkg;

    localparam int BURST_LEN = 4;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_RSVD  = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE   = 3'd0,
        BK_OPEN   = 3'd1,
        BK_WRITE  = 3'd2,
        BK_READ   = 3'd3,
        BK_WRBACK = 3'd4,
        BK_PRECH  = 3'd5
    } bank_st_e;

endpackage

// File: rtl/sdram_ap_burst.sv
module sdram_ap_burst
    import sdram_ap_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int COL_W = 4,
    parameter int BLEN  = BURST_LEN
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      start_wr_i,
    input  logic                      start_ap_i,
    input  logic [$clog2(NBANK)-1:0]  start_bank_i,
    input  logic [COL_W-1:0]          start_col_i,
    output logic                      beat_o,
    output logic                      beat_wr_o,
    output logic [$clog2(NBANK)-1:0]  beat_bank_o,
    output logic [COL_W-1:0]          beat_col_o,
    output logic                      end_o,
    output logic [$clog2(NBANK)-1:0]  end_bank_o,
    output logic                      end_wr_o,
    output logic                      end_ap_o,
    output logic                      busy_o,
    output logic [$clog2(NBANK)-1:0]  own_bank_o,
    output logic                      own_ap_o
);

    localparam int BANK_W = $clog2(NBANK);
    localparam int LOW_W  = $clog2(BLEN);
    localparam int HI_W   = COL_W - LOW_W;

    typedef struct packed {
        logic              busy;
        logic              wr;
        logic              ap;
        logic [BANK_W-1:0] bank;
        logic [HI_W-1:0]   hi;
        logic [LOW_W-1:0]  lo;
        logic [LOW_W-1:0]  left;
    } burst_t;

    burst_t burst_d, burst_q;

    always_comb begin
        burst_d     = burst_q;
        beat_o      = 1'b0;
        beat_wr_o   = burst_q.wr;
        beat_bank_o = burst_q.bank;
        beat_col_o  = {burst_q.hi, burst_q.lo};
        end_o       = 1'b0;
        end_bank_o  = burst_q.bank;
        end_wr_o    = burst_q.wr;
        end_ap_o    = burst_q.ap;
        if (start_i) begin
            beat_o       = 1'b1;
            beat_wr_o    = start_wr_i;
            beat_bank_o  = start_bank_i;
            beat_col_o   = start_col_i;
            end_o        = burst_q.busy;
            burst_d.busy = 1'b1;
            burst_d.wr   = start_wr_i;
            burst_d.ap   = start_ap_i;
            burst_d.bank = start_bank_i;
            burst_d.hi   = start_col_i[COL_W-1:LOW_W];
            burst_d.lo   = start_col_i[LOW_W-1:0] + 1'b1;
            burst_d.left = LOW_W'(BLEN - 1);
        end else if (burst_q.busy) begin
            beat_o       = 1'b1;
            burst_d.lo   = burst_q.lo + 1'b1;
            burst_d.left = burst_q.left - 1'b1;
            if (burst_q.left == LOW_W'(1)) begin
                end_o        = 1'b1;
                burst_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) burst_q <= '0;
        else        burst_q <= burst_d;
    end

    assign busy_o     = burst_q.busy;
    assign own_bank_o = burst_q.bank;
    assign own_ap_o   = burst_q.ap;

    AST_BUSY_HAS_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_q.busy && !start_i && burst_q.left == LOW_W'(1)) |=> !burst_q.busy); // R3

endmodule

// File: rtl/sdram_ap_bank.sv
module sdram_ap_bank
    import sdram_ap_pkg::*;
#(
    parameter int WR_REC_CYC = 2,
    parameter int PRECH_CYC  = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     go_wr_i,
    input  logic     go_rd_i,
    input  logic     end_i,
    input  logic     end_wr_i,
    input  logic     end_ap_i,
    output bank_st_e st_o
);

    localparam int MAXC  = (WR_REC_CYC > PRECH_CYC) ? WR_REC_CYC : PRECH_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    typedef struct packed {
        bank_st_e         st;
        logic [CNT_W-1:0] cnt;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (go_wr_i) begin
            bk_d.st  = BK_WRITE;
            bk_d.cnt = '0;
        end else if (go_rd_i) begin
            bk_d.st  = BK_READ;
            bk_d.cnt = '0;
        end else if (end_i) begin
            if (!end_ap_i) begin
                bk_d.st = BK_OPEN;
            end else if (end_wr_i) begin
                bk_d.st  = BK_WRBACK;
                bk_d.cnt = CNT_W'(WR_REC_CYC - 1);
            end else begin
                bk_d.st  = BK_PRECH;
                bk_d.cnt = CNT_W'(PRECH_CYC - 1);
            end
        end else begin
            case (bk_q.st)
                BK_WRBACK: begin
                    if (bk_q.cnt == '0) begin
                        bk_d.st  = BK_PRECH;
                        bk_d.cnt = CNT_W'(PRECH_CYC - 1);
                    end else begin
                        bk_d.cnt = bk_q.cnt - 1'b1;
                    end
                end
                BK_PRECH: begin
                    if (bk_q.cnt == '0) bk_d.st  = BK_IDLE;
                    else                bk_d.cnt = bk_q.cnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bk_q.st  <= BK_OPEN;
            bk_q.cnt <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign st_o = bk_q.st;

    AST_WRBACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (bk_q.st == BK_WRBACK) |=> (bk_q.st == BK_WRBACK || bk_q.st == BK_PRECH)); // R4
    AST_PRECH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (bk_q.st == BK_PRECH) |=> (bk_q.st == BK_PRECH || bk_q.st == BK_IDLE)); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bk_q.st == BK_IDLE) |=> (bk_q.st == BK_IDLE)); // R8

endmodule

// File: rtl/sdram_ap_rdpipe.sv
module sdram_ap_rdpipe #(
    parameter int CAS_LAT = 3,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld_i,
    input  logic [DATA_W-1:0] in_data_i,
    output logic              out_vld_o,
    output logic [DATA_W-1:0] out_data_o
);

    logic [CAS_LAT-1:0] vld_d, vld_q;
    logic [DATA_W-1:0]  dat_d [CAS_LAT];
    logic [DATA_W-1:0]  dat_q [CAS_LAT];

    always_comb begin
        vld_d[0] = in_vld_i;
        dat_d[0] = in_data_i;
        for (int s = 1; s < CAS_LAT; s++) begin
            vld_d[s] = vld_q[s-1];
            dat_d[s] = dat_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int s = 0; s < CAS_LAT; s++) dat_q[s] <= '0;
        end else begin
            vld_q <= vld_d;
            for (int s = 0; s < CAS_LAT; s++) dat_q[s] <= dat_d[s];
        end
    end

    assign out_vld_o  = vld_q[CAS_LAT-1];
    assign out_data_o = vld_q[CAS_LAT-1] ? dat_q[CAS_LAT-1] : '0;

endmodule

// File: rtl/sdram_ap_seq.sv
module sdram_ap_seq
    import sdram_ap_pkg::*;
#(
    parameter int NBANK      = 4,
    parameter int COL_W      = 4,
    parameter int DATA_W     = 16,
    parameter int WR_REC_CYC = 2,
    parameter int PRECH_CYC  = 3,
    parameter int CAS_LAT    = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cmd_i,
    input  logic                     ap_i,
    input  logic [$clog2(NBANK)-1:0] bank_i,
    input  logic [COL_W-1:0]         col_i,
    input  logic [DATA_W-1:0]        wdata_i,
    output logic [3*NBANK-1:0]       bank_state_o,
    output logic                     mem_we_o,
    output logic [$clog2(NBANK)-1:0] mem_bank_o,
    output logic [COL_W-1:0]         mem_col_o,
    output logic [DATA_W-1:0]        mem_wdata_o,
    output logic [DATA_W-1:0]        rdata_o,
    output logic                     rdata_oe_o,
    output logic                     cmd_err_o
);

    localparam int BANK_W = $clog2(NBANK);
    localparam int ADDR_W = BANK_W + COL_W;
    localparam int DEPTH  = 1 << ADDR_W;

    cmd_e                    cmd;
    logic                    is_rd, is_wr, accept;
    logic [NBANK-1:0][2:0]   st_w;
    logic [NBANK-1:0]        owner_vec;
    logic                    tgt_live, tgt_locked;

    logic                    beat, beat_wr, b_end, b_end_wr, b_end_ap, busy, own_ap;
    logic [BANK_W-1:0]       beat_bank, b_end_bank, own_bank;
    logic [COL_W-1:0]        beat_col;
    logic [ADDR_W-1:0]       addr;
    logic [DATA_W-1:0]       mem_q [DEPTH];

    always_comb begin
        cmd        = cmd_e'(cmd_i);
        is_rd      = (cmd == CMD_READ);
        is_wr      = (cmd == CMD_WRITE);
        tgt_live   = st_w[bank_i] inside {BK_OPEN, BK_WRITE, BK_READ};
        tgt_locked = busy && own_ap && (own_bank == bank_i);
        cmd_err_o  = (is_rd || is_wr) && (!tgt_live || tgt_locked);
        accept     = (is_rd || is_wr) && !cmd_err_o;
    end

    sdram_ap_burst #(
        .NBANK (NBANK),
        .COL_W (COL_W)
    ) u_burst (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (accept),
        .start_wr_i   (is_wr),
        .start_ap_i   (ap_i),
        .start_bank_i (bank_i),
        .start_col_i  (col_i),
        .beat_o       (beat),
        .beat_wr_o    (beat_wr),
        .beat_bank_o  (beat_bank),
        .beat_col_o   (beat_col),
        .end_o        (b_end),
        .end_bank_o   (b_end_bank),
        .end_wr_o     (b_end_wr),
        .end_ap_o     (b_end_ap),
        .busy_o       (busy),
        .own_bank_o   (own_bank),
        .own_ap_o     (own_ap)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bank_st_e st_b;
        sdram_ap_bank #(
            .WR_REC_CYC (WR_REC_CYC),
            .PRECH_CYC  (PRECH_CYC)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .go_wr_i  (accept && is_wr && (bank_i == BANK_W'(b))),
            .go_rd_i  (accept && is_rd && (bank_i == BANK_W'(b))),
            .end_i    (b_end && (b_end_bank == BANK_W'(b))),
            .end_wr_i (b_end_wr),
            .end_ap_i (b_end_ap),
            .st_o     (st_b)
        );
        assign st_w[b]              = st_b;
        assign bank_state_o[3*b +: 3] = st_b;
        assign owner_vec[b]         = (st_b == BK_WRITE) || (st_b == BK_READ);
    end

    assign addr        = {beat_bank, beat_col};
    assign mem_we_o    = beat && beat_wr;
    assign mem_bank_o  = beat_bank;
    assign mem_col_o   = beat_col;
    assign mem_wdata_o = wdata_i;

    always_ff @(posedge clk) begin
        if (mem_we_o) mem_q[addr] <= wdata_i;
    end

    sdram_ap_rdpipe #(
        .CAS_LAT (CAS_LAT),
        .DATA_W  (DATA_W)
    ) u_rdpipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vld_i   (beat && !beat_wr),
        .in_data_i  (mem_q[addr]),
        .out_vld_o  (rdata_oe_o),
        .out_data_o (rdata_o)
    );

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(owner_vec)); // R3
    AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_err_o && !busy) |-> !mem_we_o); // R8
    AST_WE_LIVE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (st_w[mem_bank_o] inside {BK_OPEN, BK_WRITE, BK_READ})); // R4

endmodule

// File: tb/sdram_ap_seq_bench.sv
`timescale 1ns/1ps
module sdram_ap_seq_bench;

    localparam int TWR = 2;
    localparam int TRP = 3;
    localparam int CL  = 3;
    localparam logic [2:0] S_IDLE = 3'd0, S_OPEN = 3'd1, S_WR = 3'd2,
                           S_RD = 3'd3, S_WB = 3'd4, S_PC = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd = 2'd0;
    logic        ap = 1'b0;
    logic [1:0]  bank = 2'd0;
    logic [3:0]  col = 4'd0;
    logic [15:0] wd = 16'd0;
    logic [11:0] bank_state;
    logic        we, oe, err;
    logic [1:0]  wbank;
    logic [3:0]  wcol;
    logic [15:0] wdat, rdat;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sdram_ap_seq #(
        .NBANK(4), .COL_W(4), .DATA_W(16),
        .WR_REC_CYC(TWR), .PRECH_CYC(TRP), .CAS_LAT(CL)
    ) u_sdram_ap_seq (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .ap_i(ap), .bank_i(bank),
        .col_i(col), .wdata_i(wd), .bank_state_o(bank_state),
        .mem_we_o(we), .mem_bank_o(wbank), .mem_col_o(wcol),
        .mem_wdata_o(wdat), .rdata_o(rdat), .rdata_oe_o(oe), .cmd_err_o(err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] st_of(input int b);
        return bank_state[3*b +: 3];
    endfunction

    function automatic logic [31:0] wpack();
        return we ? {9'd0, 1'b1, wbank, wcol, wdat} : 32'd0;
    endfunction

    function automatic logic [31:0] epack(input int b, input int c, input logic [15:0] d);
        return {9'd0, 1'b1, b[1:0], c[3:0], d};
    endfunction

    task automatic drive(input logic [1:0] c, input logic a, input int b,
                         input int cl, input logic [15:0] w);
        cmd = c; ap = a; bank = b[1:0]; col = cl[3:0]; wd = w;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drive(2'd0, 1'b0, 0, 0, 16'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [15:0] dpre(input int m, input int j);
        return 16'hA000 | 16'(m << 8) | 16'(j);
    endfunction

    task automatic run_case(input int n, input int m, input int k,
                            input bit rd, input bit apm);
        int i, j;
        logic [2:0] en, em;
        logic [31:0] ew;
        bit eoe, eerr;
        logic [15:0] wv;
        do_reset();
        // prefill bank m, columns 4..7
        for (int c = 0; c < 5; c++) begin
            if (c == 0)     drive(2'd2, 1'b0, m, 4, dpre(m, 0));
            else if (c < 4) drive(2'd0, 1'b0, 0, 0, dpre(m, c));
            else            drive(2'd0, 1'b0, 0, 0, 16'd0);
            #1;
            chk("R2 prefill write", wpack(), (c < 4) ? epack(m, 4 + c, dpre(m, c)) : 32'd0);
            @(negedge clk);
        end
        for (int r = 0; r <= k + 12; r++) begin
            i = r - k;
            // bank n expectation
            if (r == 0)                en = S_OPEN;
            else if (r <= k)           en = S_WR;
            else if (i <= TWR)         en = S_WB;
            else if (i <= TWR + TRP)   en = S_PC;
            else                       en = S_IDLE;
            // bank m expectation
            if (i <= 0)                em = S_OPEN;
            else if (i <= 3)           em = rd ? S_RD : S_WR;
            else if (!apm)             em = S_OPEN;
            else if (rd)               em = (i - 4 < TRP) ? S_PC : S_IDLE;
            else if (i - 4 < TWR)      em = S_WB;
            else if (i - 4 < TWR + TRP) em = S_PC;
            else                       em = S_IDLE;
            chk((r <= k) ? "R3 bank n before cut" : "R4 bank n recovery", 32'(st_of(n)), 32'(en));
            chk(rd ? (apm ? "R7 bank m read ap" : "R6 bank m read")
                   : "R5 bank m write", 32'(st_of(m)), 32'(em));
            for (int ob = 0; ob < 4; ob++)
                if (ob != n && ob != m) chk("R3 other bank", 32'(st_of(ob)), 32'(S_OPEN));
            j = i - CL;
            eoe = rd && (j >= 0) && (j <= 3);
            chk("R6 read enable", 32'(oe), 32'(eoe));
            if (eoe) chk("R6 read data", 32'(rdat), 32'(dpre(m, (2 + j) % 4)));
            // stimulus
            wv = (i >= 0 && i <= 3) ? (16'hC000 | 16'(i)) : 16'd0;
            eerr = 1'b0;
            if (r < k)                 drive(r == 0 ? 2'd2 : 2'd0, r == 0, n, 9, 16'hB000 | 16'(r));
            else if (i == 0)           drive(rd ? 2'd1 : 2'd2, apm, m, rd ? 6 : 15, wv);
            else if (i == 1)           begin drive(2'd2, 1'b0, n, 0, wv); eerr = 1'b1; end
            else if (i == TWR + 1)     begin drive(2'd1, 1'b0, n, 0, wv); eerr = 1'b1; end
            else if (i == TWR + TRP + 2) begin drive(2'd2, 1'b0, n, 0, wv); eerr = 1'b1; end
            else                       drive(2'd0, 1'b0, 0, 0, wv);
            #1;
            if (r < k)                 ew = epack(n, 8 + ((1 + r) % 4), 16'hB000 | 16'(r));
            else if (!rd && i <= 3)    ew = epack(m, 12 + ((3 + i) % 4), wv);
            else                       ew = 32'd0;
            chk((r < k) ? "R2 bank n beat" : (r == k ? "R3 cut edge" : "R8 after cut"), wpack(), ew);
            chk("R8 reject flag", 32'(err), 32'(eerr));
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state and reserved command code
        do_reset();
        for (int b = 0; b < 4; b++) chk("R1 reset state", 32'(st_of(b)), 32'(S_OPEN));
        chk("R1 reset enable", 32'(oe), 32'd0);
        drive(2'd3, 1'b1, 1, 3, 16'h1234);
        #1;
        chk("R1 reserved code no write", wpack(), 32'd0);
        chk("R1 reserved code no error", 32'(err), 32'd0);
        @(negedge clk);
        chk("R1 reserved code no state", 32'(st_of(1)), 32'(S_OPEN));
        // R8: own auto-precharge burst locks its bank; R5 natural completion
        drive(2'd2, 1'b1, 0, 2, 16'hD000);
        #1;
        chk("R2 first beat", wpack(), epack(0, 2, 16'hD000));
        @(negedge clk);
        drive(2'd1, 1'b0, 0, 0, 16'hD001);
        #1;
        chk("R8 locked bank flag", 32'(err), 32'd1);
        chk("R8 burst continues", wpack(), epack(0, 3, 16'hD001));
        @(negedge clk);
        for (int c = 2; c < 4; c++) begin
            drive(2'd0, 1'b0, 0, 0, 16'hD000 | 16'(c));
            #1;
            chk("R2 wrap beat", wpack(), epack(0, (2 + c) % 4, 16'hD000 | 16'(c)));
            @(negedge clk);
        end
        drive(2'd0, 1'b0, 0, 0, 16'd0);
        chk("R5 natural recovery", 32'(st_of(0)), 32'(S_WB));
        @(negedge clk);
        @(negedge clk);
        chk("R5 natural precharge", 32'(st_of(0)), 32'(S_PC));
        // sweep
        for (int n = 0; n < 4; n++)
            for (int m = 0; m < 4; m++)
                if (n != m)
                    for (int k = 1; k < 4; k++)
                        for (int rd = 0; rd < 2; rd++)
                            for (int apm = 0; apm < 2; apm++)
                                run_case(n, m, k, rd[0], apm[0]);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule